// File: doc/BRIEF.md
# SDRAM Timing Parameter Calculator

This block converts datasheet timing values, given in picoseconds, into the cycle-count fields that an SDRAM controller loads for a given DDR clock period. A request carries the clock period, the DDR frequency in kHz, the timing values, the minimum cycle counts, an eight-bank flag and a derate select. The block captures the request, then works through the fields one at a time. One shared restoring divider performs every division, so only one division is in progress at any moment. It then pulses a done strobe. The derate select gives the high-temperature form of the timing words and the refresh word.

The request side is a valid/ready stream. `in_ready` is high only while the block is idle, and a request is taken in any cycle where `in_valid` and `in_ready` are both high. All request fields are captured at that edge, so the source may change them afterwards. The result side is a single-cycle `out_valid` strobe with no back-pressure. The sink must take the fields on the strobe, or read them later, because they hold until the next request is accepted.

Top module: `tcalc_top`

## Requirements
- R1: After reset and between requests `in_ready` is 1. A request is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 until the cycle after the `out_valid` strobe, when it is 1 again.
- R2: `out_valid` is 1 for exactly one cycle per accepted request, in the cycle after the last field is written.
- R3: Reset clears every output field to 0. After `out_valid` the fields hold their values until the next request is accepted, whatever the request inputs do.
- R4: The write-to-read, write-recovery, activate-to-command, precharge and active-time fields each equal max(min, ceil(t/tck)) − 1, using the matching minimum count.
- R5: With `eight_bank` = 0 the row-to-row field is max(min_rrd, ceil(trrd/tck)) − 1.
- R6: With `eight_bank` = 1 the row-to-row field is ceil(tfaw/(4·tck)) − 1, and `min_rrd` has no effect.
- R7: The row-cycle field is ceil((tras + trp)/tck) − 1, with no minimum count.
- R8: With `derate` = 1, 1875 ps is added to trrd, to the row-cycle sum, to tras, to trcd and to trp before dividing, and 7500 ps is added to tfaw. The write-to-read and write-recovery fields are the same as with `derate` = 0.
- R9: The two self-refresh exit fields both equal ceil((trfc + 10000)/tck) − 1.
- R10: With q = floor(tras_max_ns/trefi_ns), the maximum active-time field is 0 when q is 0, and otherwise min(q − 1, 15).
- R11: The refresh field is floor(floor(trefi_ns/100) · f / 10000). Here f is `freq_khz` with `derate` = 0 and floor(`freq_khz`/4) with `derate` = 1. The result saturates at 65535.
- R12: A cycle field saturates at 255, and a field whose max() term is 0 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block idle, request accepted when valid |
| tck_ps | input | 16 | DDR clock period in ps |
| freq_khz | input | 20 | DDR frequency in kHz |
| trefi_ns | input | 16 | Average refresh interval in ns |
| tras_max_ns | input | 24 | Maximum active time in ns |
| trfc_ps | input | 20 | Refresh cycle time in ps |
| twtr_ps | input | 20 | Write-to-read time in ps |
| trrd_ps | input | 20 | Row-to-row time in ps |
| tfaw_ps | input | 20 | Four-activate window in ps |
| tras_ps | input | 20 | Minimum active time in ps |
| trp_ps | input | 20 | Precharge time in ps |
| twr_ps | input | 20 | Write-recovery time in ps |
| trcd_ps | input | 20 | Activate-to-command time in ps |
| min_wtr | input | 4 | Minimum write-to-read cycles |
| min_rrd | input | 4 | Minimum row-to-row cycles |
| min_ras | input | 4 | Minimum active cycles |
| min_wr | input | 4 | Minimum write-recovery cycles |
| min_rcd | input | 4 | Minimum activate-to-command cycles |
| min_rp | input | 4 | Minimum precharge cycles |
| eight_bank | input | 1 | Device has eight banks |
| derate | input | 1 | Produce high-temperature derated values |
| out_valid | output | 1 | One-cycle done strobe |
| f_wtr | output | 8 | Write-to-read field |
| f_rrd | output | 8 | Row-to-row field |
| f_rc | output | 8 | Row-cycle field |
| f_ras | output | 8 | Active-time field |
| f_wr | output | 8 | Write-recovery field |
| f_rcd | output | 8 | Activate-to-command field |
| f_rp | output | 8 | Precharge field |
| f_xsnr | output | 8 | Self-refresh exit field, non-read |
| f_xsrd | output | 8 | Self-refresh exit field, read |
| f_rasmax | output | 4 | Maximum active-time field |
| f_ref | output | 16 | Refresh interval field |

## Verification
The checker watches the handshake on every cycle. It checks that `in_ready` drops after an accepted request and comes back after the strobe, that the strobe lasts one cycle and never follows straight on from an acceptance, and that the fields stay still while the block is idle. Only the bench's scenarios can show the arithmetic: the ceiling divisions, the minimum counts, the eight-bank path, the derating margins, and the saturation of the cycle, maximum active-time and refresh fields. The bench compares every field with values it computes itself.

// File: rtl/tcalc_pkg.sv
package tcalc_pkg;
  localparam int unsigned QW = 32;

  typedef enum logic [3:0] {
    ST_WTR, ST_RRD, ST_RC, ST_RAS, ST_WR, ST_RCD, ST_RP,
    ST_XS, ST_RMAX, ST_RDIV, ST_REF
  } step_e;

  localparam step_e LAST_STEP = ST_REF;

  // max(q, m) - 1, zero stays zero, clipped to lim
  function automatic logic [QW-1:0] cyc_field(logic [QW-1:0] q, logic [QW-1:0] m,
                                               logic [QW-1:0] lim);
    logic [QW-1:0] v;
    v = (q > m) ? q : m;
    if (v == '0) return '0;
    v = v - 1'b1;
    return (v > lim) ? lim : v;
  endfunction
endpackage

// File: rtl/tcalc_div.sv
module tcalc_div #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [DW-1:0] quotient
);
  localparam int unsigned CNTW = $clog2(DW + 1);

  logic [DW-1:0]   rem_q, dvsr_q;
  logic [CNTW-1:0] cnt_q;
  logic [DW:0]     shifted;

  assign shifted = {rem_q, quotient[DW-1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q    <= '0;
      dvsr_q   <= '0;
      quotient <= '0;
      cnt_q    <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q    <= '0;
        dvsr_q   <= divisor;
        quotient <= dividend;
        cnt_q    <= CNTW'(DW);
      end else if (cnt_q != '0) begin
        if (shifted >= {1'b0, dvsr_q}) begin
          rem_q    <= DW'(shifted - {1'b0, dvsr_q});
          quotient <= {quotient[DW-2:0], 1'b1};
        end else begin
          rem_q    <= shifted[DW-1:0];
          quotient <= {quotient[DW-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        done  <= (cnt_q == CNTW'(1));
      end
    end
  end
endmodule

// File: rtl/tcalc_opsel.sv
module tcalc_opsel
  import tcalc_pkg::*;
#(
  parameter int unsigned TW  = 20,
  parameter int unsigned CW  = 16,
  parameter int unsigned NW  = 16,
  parameter int unsigned RMW = 24,
  parameter int unsigned FKW = 20,
  parameter int unsigned MW  = 4
) (
  input  step_e          step,
  input  logic [CW-1:0]  tck,
  input  logic [FKW-1:0] fkhz,
  input  logic [NW-1:0]  trefi,
  input  logic [RMW-1:0] trasmax,
  input  logic [TW-1:0]  trfc, twtr, trrd, tfaw, tras, trp, twr, trcd,
  input  logic [MW-1:0]  mwtr, mrrd, mras, mwr, mrcd, mrp,
  input  logic           eight,
  input  logic           der,
  input  logic [QW-1:0]  ref_mid,
  output logic [QW-1:0]  num,
  output logic [QW-1:0]  den,
  output logic [QW-1:0]  minc
);
  localparam logic [QW-1:0] MARGIN_ONE  = QW'(1875);
  localparam logic [QW-1:0] MARGIN_FAW  = QW'(7500);
  localparam logic [QW-1:0] EXIT_EXTRA  = QW'(10000);

  logic [QW-1:0] m_s, m_f, a, tk, fsel, prod;
  logic          ceil_en;

  assign m_s  = der ? MARGIN_ONE : '0;
  assign m_f  = der ? MARGIN_FAW : '0;
  assign tk   = QW'(tck);
  assign fsel = der ? QW'(fkhz >> 2) : QW'(fkhz);
  assign prod = ref_mid * fsel;

  always_comb begin
    a       = '0;
    den     = tk;
    minc    = '0;
    ceil_en = 1'b1;
    unique case (step)
      ST_WTR: begin a = QW'(twtr); minc = QW'(mwtr); end
      ST_RRD: begin
        if (eight) begin a = QW'(tfaw) + m_f; den = tk << 2; end
        else       begin a = QW'(trrd) + m_s; minc = QW'(mrrd); end
      end
      ST_RC:  a = QW'(tras) + QW'(trp) + m_s;
      ST_RAS: begin a = QW'(tras) + m_s; minc = QW'(mras); end
      ST_WR:  begin a = QW'(twr); minc = QW'(mwr); end
      ST_RCD: begin a = QW'(trcd) + m_s; minc = QW'(mrcd); end
      ST_RP:  begin a = QW'(trp) + m_s; minc = QW'(mrp); end
      ST_XS:  a = QW'(trfc) + EXIT_EXTRA;
      ST_RMAX: begin a = QW'(trasmax); den = QW'(trefi); ceil_en = 1'b0; end
      ST_RDIV: begin a = QW'(trefi); den = QW'(100); ceil_en = 1'b0; end
      ST_REF:  begin a = prod; den = QW'(10000); ceil_en = 1'b0; end
      default: a = '0;
    endcase
    num = ceil_en ? (a + den - 1'b1) : a;
  end
endmodule

// File: rtl/tcalc_top.sv
module tcalc_top
  import tcalc_pkg::*;
#(
  parameter int unsigned TW  = 20,
  parameter int unsigned CW  = 16,
  parameter int unsigned NW  = 16,
  parameter int unsigned RMW = 24,
  parameter int unsigned FKW = 20,
  parameter int unsigned MW  = 4,
  parameter int unsigned FW  = 8,
  parameter int unsigned XW  = 4,
  parameter int unsigned RW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [CW-1:0]  tck_ps,
  input  logic [FKW-1:0] freq_khz,
  input  logic [NW-1:0]  trefi_ns,
  input  logic [RMW-1:0] tras_max_ns,
  input  logic [TW-1:0]  trfc_ps,
  input  logic [TW-1:0]  twtr_ps,
  input  logic [TW-1:0]  trrd_ps,
  input  logic [TW-1:0]  tfaw_ps,
  input  logic [TW-1:0]  tras_ps,
  input  logic [TW-1:0]  trp_ps,
  input  logic [TW-1:0]  twr_ps,
  input  logic [TW-1:0]  trcd_ps,
  input  logic [MW-1:0]  min_wtr,
  input  logic [MW-1:0]  min_rrd,
  input  logic [MW-1:0]  min_ras,
  input  logic [MW-1:0]  min_wr,
  input  logic [MW-1:0]  min_rcd,
  input  logic [MW-1:0]  min_rp,
  input  logic           eight_bank,
  input  logic           derate,
  output logic           out_valid,
  output logic [FW-1:0]  f_wtr,
  output logic [FW-1:0]  f_rrd,
  output logic [FW-1:0]  f_rc,
  output logic [FW-1:0]  f_ras,
  output logic [FW-1:0]  f_wr,
  output logic [FW-1:0]  f_rcd,
  output logic [FW-1:0]  f_rp,
  output logic [FW-1:0]  f_xsnr,
  output logic [FW-1:0]  f_xsrd,
  output logic [XW-1:0]  f_rasmax,
  output logic [RW-1:0]  f_ref
);
  localparam logic [QW-1:0] FLIM = QW'((1 << FW) - 1);
  localparam logic [QW-1:0] XLIM = QW'((1 << XW) - 1);
  localparam logic [QW-1:0] RLIM = QW'((1 << RW) - 1);

  typedef enum logic [1:0] {S_IDLE, S_KICK, S_WAIT, S_DONE} state_e;

  state_e         state_q;
  step_e          step_q;
  logic [CW-1:0]  r_tck;
  logic [FKW-1:0] r_fk;
  logic [NW-1:0]  r_trefi;
  logic [RMW-1:0] r_rmax;
  logic [TW-1:0]  r_trfc, r_twtr, r_trrd, r_tfaw, r_tras, r_trp, r_twr, r_trcd;
  logic [MW-1:0]  r_mwtr, r_mrrd, r_mras, r_mwr, r_mrcd, r_mrp;
  logic           r_eight, r_der;
  logic [QW-1:0]  ref_mid, num, den, minc, quo, fval;
  logic           div_done;

  assign in_ready  = (state_q == S_IDLE);
  assign out_valid = (state_q == S_DONE);
  assign fval      = cyc_field(quo, minc, FLIM);

  tcalc_opsel #(.TW(TW), .CW(CW), .NW(NW), .RMW(RMW), .FKW(FKW), .MW(MW)) u_opsel (
    .step(step_q), .tck(r_tck), .fkhz(r_fk), .trefi(r_trefi), .trasmax(r_rmax),
    .trfc(r_trfc), .twtr(r_twtr), .trrd(r_trrd), .tfaw(r_tfaw), .tras(r_tras),
    .trp(r_trp), .twr(r_twr), .trcd(r_trcd),
    .mwtr(r_mwtr), .mrrd(r_mrrd), .mras(r_mras), .mwr(r_mwr), .mrcd(r_mrcd), .mrp(r_mrp),
    .eight(r_eight), .der(r_der), .ref_mid(ref_mid),
    .num(num), .den(den), .minc(minc)
  );

  tcalc_div #(.DW(QW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(state_q == S_KICK),
    .dividend(num), .divisor(den), .done(div_done), .quotient(quo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= ST_WTR;
      ref_mid <= '0;
      {r_tck, r_fk, r_trefi, r_rmax} <= '0;
      {r_trfc, r_twtr, r_trrd, r_tfaw, r_tras, r_trp, r_twr, r_trcd} <= '0;
      {r_mwtr, r_mrrd, r_mras, r_mwr, r_mrcd, r_mrp, r_eight, r_der} <= '0;
      {f_wtr, f_rrd, f_rc, f_ras, f_wr, f_rcd, f_rp, f_xsnr, f_xsrd} <= '0;
      f_rasmax <= '0;
      f_ref    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (in_valid) begin
          r_tck <= tck_ps; r_fk <= freq_khz; r_trefi <= trefi_ns; r_rmax <= tras_max_ns;
          r_trfc <= trfc_ps; r_twtr <= twtr_ps; r_trrd <= trrd_ps; r_tfaw <= tfaw_ps;
          r_tras <= tras_ps; r_trp <= trp_ps; r_twr <= twr_ps; r_trcd <= trcd_ps;
          r_mwtr <= min_wtr; r_mrrd <= min_rrd; r_mras <= min_ras;
          r_mwr <= min_wr; r_mrcd <= min_rcd; r_mrp <= min_rp;
          r_eight <= eight_bank; r_der <= derate;
          step_q  <= ST_WTR;
          state_q <= S_KICK;
        end
        S_KICK: state_q <= S_WAIT;
        S_WAIT: if (div_done) begin
          unique case (step_q)
            ST_WTR: f_wtr <= FW'(fval);
            ST_RRD: f_rrd <= FW'(fval);
            ST_RC:  f_rc  <= FW'(fval);
            ST_RAS: f_ras <= FW'(fval);
            ST_WR:  f_wr  <= FW'(fval);
            ST_RCD: f_rcd <= FW'(fval);
            ST_RP:  f_rp  <= FW'(fval);
            ST_XS:  begin f_xsnr <= FW'(fval); f_xsrd <= FW'(fval); end
            ST_RMAX: f_rasmax <= XW'(cyc_field(quo, '0, XLIM));
            ST_RDIV: ref_mid <= quo;
            ST_REF:  f_ref <= RW'((quo > RLIM) ? RLIM : quo);
            default: ref_mid <= ref_mid;
          endcase
          if (step_q == LAST_STEP) state_q <= S_DONE;
          else begin
            step_q  <= step_e'(step_q + 1'b1);
            state_q <= S_KICK;
          end
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tcalc_chk.sv
module tcalc_chk #(
  parameter int unsigned FW = 8,
  parameter int unsigned RW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [FW-1:0] f_wtr,
  input logic [FW-1:0] f_rrd,
  input logic [FW-1:0] f_rc,
  input logic [RW-1:0] f_ref
);
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_ready_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> in_ready);

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_no_strobe_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !out_valid);

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && $past(in_ready)) |-> ($stable(f_wtr) && $stable(f_rrd) &&
                                       $stable(f_rc) && $stable(f_ref)));
endmodule

bind tcalc_top tcalc_chk #(.FW(FW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .f_wtr(f_wtr), .f_rrd(f_rrd), .f_rc(f_rc), .f_ref(f_ref)
);

// File: tb/tcalc_top_test.sv
`timescale 1ns/1ps
module tcalc_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        in_valid = 1'b0;
  logic        in_ready, out_valid;
  logic [15:0] tck_ps, trefi_ns;
  logic [19:0] freq_khz, trfc_ps, twtr_ps, trrd_ps, tfaw_ps, tras_ps, trp_ps, twr_ps, trcd_ps;
  logic [23:0] tras_max_ns;
  logic [3:0]  min_wtr, min_rrd, min_ras, min_wr, min_rcd, min_rp;
  logic        eight_bank, derate;
  logic [7:0]  f_wtr, f_rrd, f_rc, f_ras, f_wr, f_rcd, f_rp, f_xsnr, f_xsrd;
  logic [3:0]  f_rasmax;
  logic [15:0] f_ref;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  tcalc_top uut (.*);

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint cdiv(longint a, longint b);
    return (a + b - 1) / b;
  endfunction

  function automatic longint fld(longint q, longint m);
    longint v;
    v = (q > m) ? q : m;
    if (v == 0) return 0;
    v = v - 1;
    return (v > 255) ? 255 : v;
  endfunction

  task automatic check_all();
    longint ms, mf, q, r, f;
    string dt;
    ms = derate ? 1875 : 0;
    mf = derate ? 7500 : 0;
    dt = derate ? "/R8" : "";
    chk({"R4 wtr", dt}, f_wtr, fld(cdiv(twtr_ps, tck_ps), min_wtr));
    chk({"R4 wr", dt},  f_wr,  fld(cdiv(twr_ps, tck_ps), min_wr));
    chk({"R4 rcd", dt}, f_rcd, fld(cdiv(trcd_ps + ms, tck_ps), min_rcd));
    chk({"R4 rp", dt},  f_rp,  fld(cdiv(trp_ps + ms, tck_ps), min_rp));
    chk({"R4 ras", dt}, f_ras, fld(cdiv(tras_ps + ms, tck_ps), min_ras));
    if (eight_bank) chk({"R6 rrd", dt}, f_rrd, fld(cdiv(tfaw_ps + mf, 4 * tck_ps), 0));
    else            chk({"R5 rrd", dt}, f_rrd, fld(cdiv(trrd_ps + ms, tck_ps), min_rrd));
    chk({"R7 rc", dt}, f_rc, fld(cdiv(longint'(tras_ps) + trp_ps + ms, tck_ps), 0));
    chk("R9 xsnr", f_xsnr, fld(cdiv(trfc_ps + 10000, tck_ps), 0));
    chk("R9 xsrd", f_xsrd, fld(cdiv(trfc_ps + 10000, tck_ps), 0));
    q = tras_max_ns / trefi_ns;
    chk("R10 rasmax", f_rasmax, (q == 0) ? 0 : ((q - 1 > 15) ? 15 : q - 1));
    f = derate ? (freq_khz / 4) : freq_khz;
    r = (trefi_ns / 100) * f / 10000;
    chk("R11 ref", f_ref, (r > 65535) ? 65535 : r);
  endtask

  task automatic run_req();
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 busy", in_ready, 0);
    while (!out_valid) @(negedge clk);
    check_all();
    @(negedge clk);
    chk("R2 pulse", out_valid, 0);
    chk("R1 ready", in_ready, 1);
  endtask

  task automatic rand_inputs();
    tck_ps      = 16'(1250 + $urandom_range(0, 8750));
    freq_khz    = 20'($urandom_range(100000, 800000));
    trefi_ns    = 16'($urandom_range(1000, 8000));
    tras_max_ns = 24'($urandom_range(0, 150000));
    trfc_ps     = 20'($urandom_range(50000, 300000));
    twtr_ps     = 20'($urandom_range(0, 20000));
    trrd_ps     = 20'($urandom_range(0, 20000));
    tfaw_ps     = 20'($urandom_range(0, 60000));
    tras_ps     = 20'($urandom_range(0, 60000));
    trp_ps      = 20'($urandom_range(0, 30000));
    twr_ps      = 20'($urandom_range(0, 20000));
    trcd_ps     = 20'($urandom_range(0, 30000));
    min_wtr = 4'($urandom); min_rrd = 4'($urandom); min_ras = 4'($urandom);
    min_wr  = 4'($urandom); min_rcd = 4'($urandom); min_rp  = 4'($urandom);
    eight_bank = 1'($urandom);
    derate     = 1'($urandom);
  endtask

  initial begin
    logic [7:0] hold_wtr, hold_rc;
    logic [15:0] hold_ref;
    void'($urandom(32'd2024));
    rand_inputs();
    repeat (3) @(negedge clk);
    chk("R1 reset ready", in_ready, 1);
    chk("R2 reset strobe", out_valid, 0);
    chk("R3 reset wtr", f_wtr, 0);
    chk("R3 reset ref", f_ref, 0);
    chk("R3 reset rasmax", f_rasmax, 0);
    rst_n = 1'b1;

    // R12 saturation and zero floor
    rand_inputs();
    tck_ps = 16'd1; twtr_ps = 20'd1000; trcd_ps = 20'd0; min_rcd = 4'd0; derate = 1'b0;
    run_req();
    chk("R12 sat", f_wtr, 255);
    chk("R12 zero", f_rcd, 0);

    // R10 both ends, R11 saturation
    rand_inputs();
    trefi_ns = 16'd65535; freq_khz = 20'hFFFFF; tras_max_ns = 24'd1000; derate = 1'b0;
    run_req();
    chk("R11 ref sat", f_ref, 65535);
    chk("R10 zero", f_rasmax, 0);
    rand_inputs();
    trefi_ns = 16'd1000; tras_max_ns = 24'd100000;
    run_req();
    chk("R10 sat", f_rasmax, 15);

    // R6 with and without derate, min_rrd ignored
    for (int d = 0; d < 2; d++) begin
      rand_inputs();
      eight_bank = 1'b1; derate = 1'(d); min_rrd = 4'd15; tck_ps = 16'd2500; tfaw_ps = 20'd50000;
      run_req();
    end

    // R8 write fields unaffected by derate
    rand_inputs();
    derate = 1'b0; run_req(); hold_wtr = f_wtr; hold_rc = f_rc;
    derate = 1'b1; run_req();
    chk("R8 wtr same", f_wtr, hold_wtr);

    // R3 hold while inputs change
    hold_wtr = f_wtr; hold_rc = f_rc; hold_ref = f_ref;
    for (int k = 0; k < 5; k++) begin
      rand_inputs();
      @(negedge clk);
    end
    chk("R3 hold wtr", f_wtr, hold_wtr);
    chk("R3 hold rc", f_rc, hold_rc);
    chk("R3 hold ref", f_ref, hold_ref);

    for (int n = 0; n < 40; n++) begin
      rand_inputs();
      run_req();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule